// File: doc/BRIEF.md
# Selective TLB Invalidation Engine

This block holds a small translation lookaside buffer, made of several arrays. Each array is set-associative. It carries out invalidate commands that clear the valid bit of chosen entries. Every entry carries these fields:

- a valid bit
- an invalidation-protect bit
- a translation ID
- an effective page number
- a page size code
- an indirect flag
- a guest-space flag

A command selects one of three invalidation kinds:

- flush everything
- flush by translation ID
- flush by address

The address kind looks only at the ways of the set that the effective address selects in each array. The other two kinds sweep every entry. The engine visits one entry per clock cycle. When the sweep ends it raises a completion pulse and a pulse asking for a full flush of any shadow translation state.

Commands enter on a valid/ready stream. `cmd_ready` is high whenever the engine is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The engine drops `cmd_ready` while a sweep runs, so a command held on the stream then waits. Any stimulus withdrawn before the sweep ends has no effect.

A privilege input and a reserved command code each turn an accepted command into a single error pulse, and no entry changes. A plain load port writes entries while the engine is idle. A combinational read port shows any entry. Both ports exist so that the buffer can be seeded and inspected.

Top module: `tlbinv_engine`

## Requirements
- R1: After reset every entry reads back as all-zero (valid clear), `busy`, `done`, `flush`, `priv_err` and `ill_err` are low, and `cmd_ready` is high.
- R2: Command type 0 clears the valid bit of every unprotected entry in all arrays. `busy` is high for exactly ARRAYS*SETS*WAYS cycles, starting the cycle after acceptance.
- R3: Command type 1 clears every unprotected entry whose translation ID equals `cmd_pid` exactly. The value on `cmd_ea` has no effect.
- R4: Command type 3 visits only entry index `{array, set, way}`, with set = `cmd_ea[PAGE_SHIFT +: log2(SETS)]`, for every array and way. `busy` stays high for ARRAYS*WAYS cycles. A visited entry is cleared when all of the following hold:
  - it is unprotected;
  - its indirect flag equals `cmd_ind`;
  - its guest-space flag equals `cmd_gs`;
  - its ID is 0 or equals `cmd_pid`;
  - its page number equals `cmd_ea[EA_W-1:PAGE_SHIFT]` on every bit at or above position 2*size code.
- R5: In type 3 with `cfg_size_match` high, an entry must also have a size code equal to `cmd_size` to be cleared. With it low, the size code is not compared.
- R6: An entry with its protect bit set is never cleared by any command type.
- R7: An accepted privileged command of type 2 raises `ill_err` for one cycle, the cycle after acceptance. It starts no sweep, gives no `done`, and changes no entry.
- R8: A command accepted with `priv` low raises `priv_err` for one cycle, the cycle after acceptance. This takes precedence over the reserved-type check. It starts no sweep and changes no entry.
- R9: `done` and `flush` pulse high together for exactly one cycle, the cycle after the last visited entry, and `busy` is low in that cycle.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both high. An accepted legal privileged command raises `busy` the next cycle. `cmd_ready` is low while `busy` is high, so commands and loads presented during a sweep have no effect.
- R11: The read port returns the stored fields of entry `rd_idx` combinationally.
- R12: When idle, `ld_en` writes all fields of entry `ld_idx` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_type | input | 2 | 0 all, 1 by ID, 2 reserved, 3 by address |
| cmd_ea | input | EA_W | Effective address for type 3 |
| cmd_pid | input | TID_W | Search translation ID |
| cmd_ind | input | 1 | Search indirect flag |
| cmd_gs | input | 1 | Search guest-space flag |
| cmd_size | input | SZ_W | Search page size code |
| cfg_size_match | input | 1 | Enables size comparison in type 3 |
| priv | input | 1 | Privileged mode |
| ld_en | input | 1 | Load entry |
| ld_idx | input | IDX_W | Entry to load |
| ld_valid | input | 1 | Loaded valid bit |
| ld_iprot | input | 1 | Loaded protect bit |
| ld_tid | input | TID_W | Loaded translation ID |
| ld_epn | input | EPN_W | Loaded page number |
| ld_size | input | SZ_W | Loaded size code |
| ld_ind | input | 1 | Loaded indirect flag |
| ld_gs | input | 1 | Loaded guest-space flag |
| rd_idx | input | IDX_W | Entry to read |
| rd_valid | output | 1 | Read valid bit |
| rd_iprot | output | 1 | Read protect bit |
| rd_tid | output | TID_W | Read translation ID |
| rd_epn | output | EPN_W | Read page number |
| rd_size | output | SZ_W | Read size code |
| rd_ind | output | 1 | Read indirect flag |
| rd_gs | output | 1 | Read guest-space flag |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished pulse |
| flush | output | 1 | Shadow translation flush pulse |
| priv_err | output | 1 | Privileged-operation error pulse |
| ill_err | output | 1 | Illegal-instruction error pulse |

## Verification
A wrong step counter or end-of-sweep compare shows at the ports as a `busy` window of the wrong length. It also shows as `done` in the wrong cycle, and this is visible as soon as the first command finishes. A wrong latched command field or a wrong set-index composition shows up only through the read port after `done`. It appears either as an entry that survives when it should not, or as an entry outside the selected set that is lost. So every sweep is followed by a readback of the whole buffer, compared against a model. A protect bit that is ignored is caught by the checker in the very cycle the clear is issued.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  typedef enum logic [1:0] {
    INV_ALL     = 2'd0,
    INV_BY_PID  = 2'd1,
    INV_RSVD    = 2'd2,
    INV_BY_ADDR = 2'd3
  } inv_kind_e;
endpackage

// File: rtl/tlbinv_store.sv
module tlbinv_store #(
  parameter int N     = 16,
  parameter int ENT_W = 35,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             kill_en,
  input  logic [IDX_W-1:0] kill_idx,
  input  logic [IDX_W-1:0] walk_idx,
  output logic [ENT_W-1:0] walk_data,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [ENT_W-1:0] peek_data
);
  logic [ENT_W-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_data;
      if (kill_en) mem[kill_idx][ENT_W-1] <= 1'b0;
    end
  end

  assign walk_data = mem[walk_idx];
  assign peek_data = mem[peek_idx];
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int TID_W       = 8,
  parameter int EPN_W       = 20,
  parameter int SZ_W        = 3,
  parameter bit GLOBAL_TID0 = 1'b1
) (
  input  inv_kind_e        kind,
  input  logic             e_prot,
  input  logic [TID_W-1:0] e_tid,
  input  logic [EPN_W-1:0] e_epn,
  input  logic [SZ_W-1:0]  e_sz,
  input  logic             e_ind,
  input  logic             e_gs,
  input  logic [TID_W-1:0] s_pid,
  input  logic [EPN_W-1:0] s_epn,
  input  logic             s_ind,
  input  logic             s_gs,
  input  logic [SZ_W-1:0]  s_sz,
  input  logic             sz_chk,
  output logic             hit
);
  logic [EPN_W-1:0] keep;
  logic             pid_eq;
  logic             pid_ok;
  logic             addr_ok;
  logic             attr_ok;

  assign keep    = {EPN_W{1'b1}} << {e_sz, 1'b0};
  assign pid_eq  = (e_tid == s_pid);
  assign addr_ok = ((e_epn ^ s_epn) & keep) == '0;
  assign attr_ok = (e_ind == s_ind) && (e_gs == s_gs) &&
                   (!sz_chk || (e_sz == s_sz));

  generate
    if (GLOBAL_TID0) begin : g_glob
      assign pid_ok = pid_eq || (e_tid == '0);
    end else begin : g_strict
      assign pid_ok = pid_eq;
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    if (!e_prot) begin
      unique case (kind)
        INV_ALL:     hit = 1'b1;
        INV_BY_PID:  hit = pid_eq;
        INV_BY_ADDR: hit = pid_ok && addr_ok && attr_ok;
        default:     hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker
  import tlbinv_pkg::*;
#(
  parameter int ARRAYS     = 2,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int TID_W      = 8,
  parameter int EA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SZ_W       = 3,
  localparam int N     = ARRAYS * SETS * WAYS,
  localparam int IDX_W = $clog2(N),
  localparam int EPN_W = EA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_type,
  input  logic [EA_W-1:0]  cmd_ea,
  input  logic [TID_W-1:0] cmd_pid,
  input  logic             cmd_ind,
  input  logic             cmd_gs,
  input  logic [SZ_W-1:0]  cmd_size,
  input  logic             cfg_size_match,
  input  logic             priv,
  output logic             busy,
  output logic [IDX_W-1:0] walk_idx,
  output inv_kind_e        kind_q,
  output logic [TID_W-1:0] pid_q,
  output logic [EPN_W-1:0] epn_q,
  output logic             ind_q,
  output logic             gs_q,
  output logic [SZ_W-1:0]  sz_q,
  output logic             szchk_q,
  output logic             done,
  output logic             flush,
  output logic             priv_err,
  output logic             ill_err
);
  localparam int SET_W    = $clog2(SETS);
  localparam int WAY_W    = $clog2(WAYS);
  localparam int ARR_W    = $clog2(ARRAYS);
  localparam int LAST_ALL = N - 1;
  localparam int LAST_SET = ARRAYS * WAYS - 1;

  logic             busy_q;
  logic [IDX_W-1:0] step_q;
  logic [IDX_W-1:0] last_step;
  logic             done_q, flush_q, perr_q, ierr_q;

  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign flush     = flush_q;
  assign priv_err  = perr_q;
  assign ill_err   = ierr_q;

  always_comb begin
    if (kind_q == INV_BY_ADDR) last_step = IDX_W'(LAST_SET);
    else                       last_step = IDX_W'(LAST_ALL);
  end

  always_comb begin
    if (kind_q == INV_BY_ADDR)
      walk_idx = {step_q[WAY_W +: ARR_W], epn_q[SET_W-1:0], step_q[WAY_W-1:0]};
    else
      walk_idx = step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      kind_q  <= INV_ALL;
      pid_q   <= '0;
      epn_q   <= '0;
      ind_q   <= 1'b0;
      gs_q    <= 1'b0;
      sz_q    <= '0;
      szchk_q <= 1'b0;
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      perr_q  <= 1'b0;
      ierr_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      flush_q <= 1'b0;
      perr_q  <= 1'b0;
      ierr_q  <= 1'b0;
      if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (step_q == last_step) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          flush_q <= 1'b1;
        end
      end else if (cmd_valid) begin
        if (!priv) begin
          perr_q <= 1'b1;
        end else if (inv_kind_e'(cmd_type) == INV_RSVD) begin
          ierr_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          step_q  <= '0;
          kind_q  <= inv_kind_e'(cmd_type);
          pid_q   <= cmd_pid;
          epn_q   <= cmd_ea[EA_W-1:PAGE_SHIFT];
          ind_q   <= cmd_ind;
          gs_q    <= cmd_gs;
          sz_q    <= cmd_size;
          szchk_q <= cfg_size_match;
        end
      end
    end
  end
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter int ARRAYS     = 2,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int TID_W      = 8,
  parameter int EA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SZ_W       = 3,
  localparam int N     = ARRAYS * SETS * WAYS,
  localparam int IDX_W = $clog2(N),
  localparam int EPN_W = EA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_type,
  input  logic [EA_W-1:0]  cmd_ea,
  input  logic [TID_W-1:0] cmd_pid,
  input  logic             cmd_ind,
  input  logic             cmd_gs,
  input  logic [SZ_W-1:0]  cmd_size,
  input  logic             cfg_size_match,
  input  logic             priv,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             ld_valid,
  input  logic             ld_iprot,
  input  logic [TID_W-1:0] ld_tid,
  input  logic [EPN_W-1:0] ld_epn,
  input  logic [SZ_W-1:0]  ld_size,
  input  logic             ld_ind,
  input  logic             ld_gs,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_iprot,
  output logic [TID_W-1:0] rd_tid,
  output logic [EPN_W-1:0] rd_epn,
  output logic [SZ_W-1:0]  rd_size,
  output logic             rd_ind,
  output logic             rd_gs,
  output logic             busy,
  output logic             done,
  output logic             flush,
  output logic             priv_err,
  output logic             ill_err
);
  localparam int OFF_GS   = 0;
  localparam int OFF_IND  = 1;
  localparam int OFF_SZ   = 2;
  localparam int OFF_EPN  = OFF_SZ + SZ_W;
  localparam int OFF_TID  = OFF_EPN + EPN_W;
  localparam int OFF_PROT = OFF_TID + TID_W;
  localparam int OFF_VAL  = OFF_PROT + 1;
  localparam int ENT_W    = OFF_VAL + 1;

  logic [ENT_W-1:0] ld_word, walk_word, peek_word;
  logic [IDX_W-1:0] walk_idx;
  inv_kind_e        kind_q;
  logic [TID_W-1:0] pid_q;
  logic [EPN_W-1:0] epn_q;
  logic             ind_q, gs_q, szchk_q;
  logic [SZ_W-1:0]  sz_q;
  logic             hit, clr_en, wr_ok;
  logic             walk_iprot;

  assign ld_word = {ld_valid, ld_iprot, ld_tid, ld_epn, ld_size, ld_ind, ld_gs};
  assign wr_ok   = ld_en && !busy;
  assign clr_en  = busy && hit;
  assign walk_iprot = walk_word[OFF_PROT];

  tlbinv_walker #(
    .ARRAYS(ARRAYS), .SETS(SETS), .WAYS(WAYS), .TID_W(TID_W),
    .EA_W(EA_W), .PAGE_SHIFT(PAGE_SHIFT), .SZ_W(SZ_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
    .cmd_ea(cmd_ea), .cmd_pid(cmd_pid), .cmd_ind(cmd_ind), .cmd_gs(cmd_gs),
    .cmd_size(cmd_size), .cfg_size_match(cfg_size_match), .priv(priv),
    .busy(busy), .walk_idx(walk_idx), .kind_q(kind_q), .pid_q(pid_q),
    .epn_q(epn_q), .ind_q(ind_q), .gs_q(gs_q), .sz_q(sz_q), .szchk_q(szchk_q),
    .done(done), .flush(flush), .priv_err(priv_err), .ill_err(ill_err)
  );

  tlbinv_store #(.N(N), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok), .wr_idx(ld_idx), .wr_data(ld_word),
    .kill_en(clr_en), .kill_idx(walk_idx),
    .walk_idx(walk_idx), .walk_data(walk_word),
    .peek_idx(rd_idx), .peek_data(peek_word)
  );

  tlbinv_match #(.TID_W(TID_W), .EPN_W(EPN_W), .SZ_W(SZ_W), .GLOBAL_TID0(1'b1)) u_match (
    .kind(kind_q),
    .e_prot(walk_word[OFF_PROT]),
    .e_tid(walk_word[OFF_TID +: TID_W]),
    .e_epn(walk_word[OFF_EPN +: EPN_W]),
    .e_sz(walk_word[OFF_SZ +: SZ_W]),
    .e_ind(walk_word[OFF_IND]),
    .e_gs(walk_word[OFF_GS]),
    .s_pid(pid_q), .s_epn(epn_q), .s_ind(ind_q), .s_gs(gs_q),
    .s_sz(sz_q), .sz_chk(szchk_q), .hit(hit)
  );

  assign rd_valid = peek_word[OFF_VAL];
  assign rd_iprot = peek_word[OFF_PROT];
  assign rd_tid   = peek_word[OFF_TID +: TID_W];
  assign rd_epn   = peek_word[OFF_EPN +: EPN_W];
  assign rd_size  = peek_word[OFF_SZ +: SZ_W];
  assign rd_ind   = peek_word[OFF_IND];
  assign rd_gs    = peek_word[OFF_GS];
endmodule

// File: rtl/tlbinv_chk.sv
module tlbinv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       priv,
  input logic [1:0] cmd_type,
  input logic       busy,
  input logic       done,
  input logic       flush,
  input logic       priv_err,
  input logic       ill_err,
  input logic       clr_en,
  input logic       walk_iprot
);
  p_priv_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !priv) |=> (priv_err && !ill_err && !busy));

  p_rsvd_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && priv && cmd_type == 2'd2) |=> (ill_err && !busy && !done));

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && priv && cmd_type != 2'd2) |=> (busy && !cmd_ready));

  p_keep_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> !walk_iprot);

  p_done_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flush && !busy && $past(busy)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind tlbinv_engine tlbinv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .priv(priv), .cmd_type(cmd_type), .busy(busy), .done(done), .flush(flush),
  .priv_err(priv_err), .ill_err(ill_err), .clr_en(clr_en), .walk_iprot(walk_iprot)
);

// File: tb/sim_tlbinv_engine.sv
module sim_tlbinv_engine;
  localparam int ARRAYS = 2, SETS = 4, WAYS = 2;
  localparam int N = ARRAYS * SETS * WAYS;
  localparam int IDXW = 4, SETW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_type = 0;
  logic [31:0] cmd_ea = 0;
  logic [7:0] cmd_pid = 0;
  logic cmd_ind = 0, cmd_gs = 0, cfg_size_match = 0, priv = 1;
  logic [2:0] cmd_size = 0;
  logic ld_en = 0, ld_valid = 0, ld_iprot = 0, ld_ind = 0, ld_gs = 0;
  logic [IDXW-1:0] ld_idx = 0, rd_idx = 0;
  logic [7:0] ld_tid = 0;
  logic [19:0] ld_epn = 0;
  logic [2:0] ld_size = 0;
  logic rd_valid, rd_iprot, rd_ind, rd_gs;
  logic [7:0] rd_tid;
  logic [19:0] rd_epn;
  logic [2:0] rd_size;
  logic busy, done, flush, priv_err, ill_err;

  tlbinv_engine u0 (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  bit m_v[N], m_p[N], m_ind[N], m_gs[N];
  logic [7:0] m_tid[N];
  logic [19:0] m_epn[N];
  logic [2:0] m_sz[N];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [63:0] a, e;
    for (int k = 0; k < N; k++) begin
      rd_idx = IDXW'(k);
      #1;
      a = {29'd0, rd_valid, rd_iprot, rd_tid, rd_epn, rd_size, rd_ind, rd_gs};
      e = {29'd0, m_v[k], m_p[k], m_tid[k], m_epn[k], m_sz[k], m_ind[k], m_gs[k]};
      chk(a == e, req, a, e);
    end
  endtask

  task automatic load(int k, bit v, bit p, logic [7:0] tid, logic [19:0] epn,
                      logic [2:0] sz, bit ind, bit gs);
    @(negedge clk);
    ld_en = 1; ld_idx = IDXW'(k); ld_valid = v; ld_iprot = p; ld_tid = tid;
    ld_epn = epn; ld_size = sz; ld_ind = ind; ld_gs = gs;
    @(negedge clk);
    ld_en = 0;
    m_v[k] = v; m_p[k] = p; m_tid[k] = tid; m_epn[k] = epn;
    m_sz[k] = sz; m_ind[k] = ind; m_gs[k] = gs;
  endtask

  // entry k has set (k / WAYS) % SETS; bits at or above 2*size are compared
  function automatic bit exp_hit(int k, int typ, logic [31:0] ea, logic [7:0] pid,
                                 bit ind, bit gs, logic [2:0] sz, bit cfg);
    int set;
    logic [19:0] diff;
    set = int'(ea[12 +: SETW]);
    if (m_p[k]) return 0;
    if (typ == 0) return 1;
    if (typ == 1) return m_tid[k] == pid;
    if (typ != 3) return 0;
    if (((k / WAYS) % SETS) != set) return 0;
    if (!(m_tid[k] == 8'd0 || m_tid[k] == pid)) return 0;
    diff = m_epn[k] ^ ea[31:12];
    if ((diff >> (2 * int'(m_sz[k]))) != 20'd0) return 0;
    if (m_ind[k] != ind || m_gs[k] != gs) return 0;
    if (cfg && m_sz[k] != sz) return 0;
    return 1;
  endfunction

  task automatic run_cmd(int typ, logic [31:0] ea, logic [7:0] pid, bit ind, bit gs,
                         logic [2:0] sz, bit pv, bit cfg, string req);
    bit hits[N];
    int cnt, n;
    for (int k = 0; k < N; k++) hits[k] = exp_hit(k, typ, ea, pid, ind, gs, sz, cfg);
    n = (typ == 3) ? ARRAYS * WAYS : N;
    @(negedge clk);
    cmd_valid = 1; cmd_type = 2'(typ); cmd_ea = ea; cmd_pid = pid; cmd_ind = ind;
    cmd_gs = gs; cmd_size = sz; priv = pv; cfg_size_match = cfg;
    @(negedge clk);
    cmd_valid = 0;
    if (!pv) begin
      chk(priv_err && !ill_err && !busy, "R8", {priv_err, ill_err, busy}, 3'b100);
      @(negedge clk);
      chk(!priv_err && !done, "R8", {priv_err, done}, 2'b00);
    end else if (typ == 2) begin
      chk(ill_err && !priv_err && !busy, "R7", {ill_err, priv_err, busy}, 3'b100);
      @(negedge clk);
      chk(!ill_err && !done, "R7", {ill_err, done}, 2'b00);
    end else begin
      chk(busy && !cmd_ready, "R10", {busy, cmd_ready}, 2'b10);
      cnt = 0;
      while (busy && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == n, (typ == 3) ? "R4" : "R2", cnt, n);
      chk(done && flush && !busy, "R9", {done, flush, busy}, 3'b110);
      @(negedge clk);
      chk(!done && !flush, "R9", {done, flush}, 2'b00);
      for (int k = 0; k < N; k++) if (hits[k]) m_v[k] = 0;
    end
    priv = 1;
    check_all(req);
  endtask

  task automatic rand_fill(int k);
    logic [19:0] e;
    e = 20'($urandom_range(0, 32'hFFFFF));
    e[SETW-1:0] = SETW'((k / WAYS) % SETS);
    load(k, $urandom_range(0, 7) != 0, $urandom_range(0, 3) == 0,
         8'($urandom_range(0, 3)), e, 3'($urandom_range(0, 3)),
         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit hits[N];
    int cnt, typ, k;
    logic [31:0] ea;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_p[i] = 0; m_ind[i] = 0; m_gs[i] = 0;
      m_tid[i] = 0; m_epn[i] = 0; m_sz[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !flush && !priv_err && !ill_err && cmd_ready, "R1",
        {busy, done, flush, priv_err, ill_err, cmd_ready}, 6'b000001);
    check_all("R1");

    // R12 / R11: load then read back
    for (int i = 0; i < N; i++)
      load(i, 1, (i % 5) == 0, 8'(i % 3), {18'(i * 7), 2'((i / WAYS) % SETS)}, 3'(i % 2),
           (i % 4) == 1, (i % 6) == 2);
    check_all("R12");
    check_all("R11");

    // R2 / R6: flush all, protected ones stay
    run_cmd(0, 32'h0, 8'd0, 0, 0, 3'd0, 1, 0, "R6");

    // R3: by id, address operand varied
    for (int i = 0; i < N; i++) rand_fill(i);
    run_cmd(1, 32'hDEADBEEF, 8'd1, 0, 0, 3'd0, 1, 0, "R3");

    // R4: tid 0 is global, size code masks low page bits
    load(4, 1, 0, 8'd0, 20'h12346, 3'd2, 0, 0);
    load(5, 1, 0, 8'd9, 20'h1234A, 3'd2, 0, 0);
    load(12, 1, 0, 8'd9, 20'h1234E, 3'd0, 0, 0);
    load(13, 1, 1, 8'd9, 20'h12342, 3'd2, 0, 0);
    run_cmd(3, {20'h12342, 12'h0}, 8'd9, 0, 0, 3'd0, 1, 0, "R4");

    // R5: size compare enabled
    load(4, 1, 0, 8'd9, 20'h0ABC6, 3'd1, 1, 1);
    load(5, 1, 0, 8'd9, 20'h0ABC6, 3'd2, 1, 1);
    run_cmd(3, {20'h0ABC6, 12'h0}, 8'd9, 1, 1, 3'd1, 1, 1, "R5");

    // R8: unprivileged, also for reserved type
    for (int i = 0; i < N; i++) rand_fill(i);
    run_cmd(0, 32'h0, 8'd0, 0, 0, 3'd0, 0, 0, "R8");
    run_cmd(2, 32'h0, 8'd0, 0, 0, 3'd0, 0, 0, "R8");
    // R7: reserved type
    run_cmd(2, 32'h0, 8'd0, 0, 0, 3'd0, 1, 0, "R7");

    // R10: command and load presented while busy are ignored
    for (int i = 0; i < N; i++) load(i, 1, 0, 8'd2, {18'd5, 2'((i / WAYS) % SETS)}, 3'd0, 0, 0);
    load(3, 1, 0, 8'd7, 20'h00001, 3'd0, 0, 0);
    for (int i = 0; i < N; i++) hits[i] = exp_hit(i, 1, 32'h0, 8'd7, 0, 0, 3'd0, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_type = 2'd1; cmd_pid = 8'd7; priv = 1;
    @(negedge clk);
    cmd_type = 2'd0; ld_en = 1; ld_idx = 4'd9; ld_valid = 1; ld_iprot = 1; ld_tid = 8'hAA;
    chk(!cmd_ready, "R10", cmd_ready, 0);
    @(negedge clk);
    cmd_valid = 0; ld_en = 0;
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    chk(done, "R10", done, 1);
    for (int i = 0; i < N; i++) if (hits[i]) m_v[i] = 0;
    check_all("R10");

    // random mix
    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < N; i++) rand_fill(i);
      case ($urandom_range(0, 6))
        0: typ = 0; 1, 2: typ = 1; 6: typ = 2; default: typ = 3;
      endcase
      k = $urandom_range(0, N - 1);
      ea = {m_epn[k], 12'($urandom_range(0, 4095))};
      if ($urandom_range(0, 3) == 0) ea[13 +: 4] = 4'($urandom_range(0, 15));
      run_cmd(typ, ea, ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 3)) : m_tid[k],
              ($urandom_range(0, 3) == 0) ? 1'($urandom_range(0, 1)) : m_ind[k],
              ($urandom_range(0, 3) == 0) ? 1'($urandom_range(0, 1)) : m_gs[k],
              3'($urandom_range(0, 3)), $urandom_range(0, 9) != 0,
              1'($urandom_range(0, 1)),
              (typ == 0) ? "R2" : (typ == 1) ? "R3" : (typ == 3) ? "R4" : "R7");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule